// File: doc/BRIEF.md
# CPU interrupt acceptance unit

This block decides, one clock at a time, whether a simple 32-bit CPU core takes a reset request, a non-maskable interrupt (NMI) or one of six level-sensitive maskable interrupt lines. When it takes an event, it raises a one-cycle redirect strobe with the new program counter. It also updates the processor status word (PSW) control bits, the exception cause register (ECR) and the saved context for that interrupt class. A return strobe from the core puts the saved PC and PSW back.

The block owns the PSW. The core reads it on `psw` and can overwrite it through a write port, for example to clear the interrupt-disable bit. Three PSW bits matter to the block: bit 7 is NMI-in-progress (NP), bit 6 is exception-in-progress (EP) and bit 5 is interrupt-disable (ID). The ECR has two cause fields. Bits 31:16 hold the NMI cause and bits 15:0 hold the maskable cause.

Top module: `irq_accept`

## Requirements
- R1: A high `reset_req` overrides every other input. On the next cycle it gives `redirect`=1 with target 0x0, `psw`=0x20 and `ecr`=0, and it discards any pending NMI.
- R2: An NMI request is taken when PSW bit 7 (NP) is clear. Taking it does the following:
  - the current PC goes to `fepc` and the PSW goes to `fepsw`;
  - NP (bit 7) and ID (bit 5) are set, and EP (bit 6) is cleared;
  - ECR bits 31:16 become 0x0010 and ECR bits 15:0 are kept;
  - the redirect target is 0x10.
- R3: An NMI that arrives while NP is set is stored as a single pending NMI. Further NMIs in that window are dropped. The pending NMI is taken on the first cycle in which NP is clear.
- R4: No maskable line is taken while NP or ID is set. An asserted line is tried again on every later cycle.
- R5: Taking a maskable line copies the PC into `eipc` and the PSW into `eipsw`. It sets ID (bit 5) and clears EP (bit 6).
- R6: Line index k (0 to 5) vectors to 0x80 + 0x10*k. ECR bits 15:0 are loaded with that vector and ECR bits 31:16 are kept.
- R7: When several maskable lines are active, the lowest index wins. An NMI that can be taken wins over any maskable line in the same cycle.
- R8: The return strobe `reti` has effect only in a cycle with no acceptance.
  - With NP set, it redirects to `fepc` and loads `psw` from `fepsw`.
  - Otherwise, it redirects to `eipc` and loads `psw` from `eipsw`.
- R9: `psw_we` loads `psw` from `psw_wdata`, but only in a cycle with no reset, acceptance or return.
- R10: `redirect` is high only in the cycle after a reset request, an acceptance or a return, and at most one of these takes effect per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| reset_req | input | 1 | Hardware reset request |
| nmi_req | input | 1 | NMI event, one pulse per NMI |
| irq | input | 6 | Maskable lines, level, index 0 highest priority |
| cur_pc | input | 32 | PC of the instruction being interrupted |
| reti | input | 1 | Return-from-interrupt strobe |
| psw_we | input | 1 | PSW write enable from the core |
| psw_wdata | input | 32 | PSW write data |
| redirect | output | 1 | One-cycle PC redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| psw | output | 32 | Processor status word |
| ecr | output | 32 | Exception cause register |
| fepc | output | 32 | PC saved by NMI |
| fepsw | output | 32 | PSW saved by NMI |
| eipc | output | 32 | PC saved by maskable interrupt |
| eipsw | output | 32 | PSW saved by maskable interrupt |

## Verification
The assertions check the following local cause-and-effect rules on every cycle:
- reset dominance;
- the NMI and maskable acceptance effects on PSW, ECR and the save registers;
- the save registers of a class staying untouched while that class is blocked;
- a return with NP set restoring the NMI context.

Some behaviours only show up over a sequence of events, so they come from the bench's scenarios. These are:
- collapsing several NMIs into a single delivery;
- delivering that NMI after a return;
- line priority among simultaneous requests;
- a blocked level line being taken once a return clears ID;
- PSW writes losing to acceptance.

// File: rtl/irq_accept.sv
`timescale 1ns/1ps
module irq_accept #(
  parameter int XLEN   = 32,
  parameter int NLINES = 6,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] MASK_BASE = 32'h80,
  parameter logic [31:0] VEC_STEP  = 32'h10,
  parameter logic [31:0] RESET_PSW = 32'h20,
  parameter logic [15:0] NMI_CAUSE = 16'h0010,
  parameter int NP_BIT = 7,
  parameter int EP_BIT = 6,
  parameter int ID_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              nmi_req,
  input  logic [NLINES-1:0] irq,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              reti,
  input  logic              psw_we,
  input  logic [XLEN-1:0]   psw_wdata,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   psw,
  output logic [XLEN-1:0]   ecr,
  output logic [XLEN-1:0]   fepc,
  output logic [XLEN-1:0]   fepsw,
  output logic [XLEN-1:0]   eipc,
  output logic [XLEN-1:0]   eipsw
);
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic          nmi_pend;
  logic [IW-1:0] irq_idx;
  logic [XLEN-1:0] mask_vec;
  logic np, id, nmi_take, mask_take;

  assign np        = psw[NP_BIT];
  assign id        = psw[ID_BIT];
  assign nmi_take  = (nmi_req | nmi_pend) & ~np;
  assign mask_take = (|irq) & ~np & ~id & ~nmi_take;

  always_comb begin
    irq_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (irq[i]) irq_idx = IW'(i);
  end

  assign mask_vec = XLEN'(MASK_BASE) + XLEN'(irq_idx) * XLEN'(VEC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      psw         <= XLEN'(RESET_PSW);
      ecr         <= '0;
      fepc        <= '0;
      fepsw       <= '0;
      eipc        <= '0;
      eipsw       <= '0;
      nmi_pend    <= 1'b0;
    end else begin
      redirect <= 1'b0;
      if (reset_req) begin
        redirect    <= 1'b1;
        redirect_pc <= '0;
        psw         <= XLEN'(RESET_PSW);
        ecr         <= '0;
        nmi_pend    <= 1'b0;
      end else if (nmi_take) begin
        redirect       <= 1'b1;
        redirect_pc    <= XLEN'(NMI_VEC);
        fepc           <= cur_pc;
        fepsw          <= psw;
        psw[NP_BIT]    <= 1'b1;
        psw[ID_BIT]    <= 1'b1;
        psw[EP_BIT]    <= 1'b0;
        ecr[31:16]     <= NMI_CAUSE;
        nmi_pend       <= nmi_pend & nmi_req;
      end else begin
        nmi_pend <= nmi_pend | nmi_req;
        if (mask_take) begin
          redirect    <= 1'b1;
          redirect_pc <= mask_vec;
          eipc        <= cur_pc;
          eipsw       <= psw;
          psw[ID_BIT] <= 1'b1;
          psw[EP_BIT] <= 1'b0;
          ecr[15:0]   <= mask_vec[15:0];
        end else if (reti) begin
          redirect    <= 1'b1;
          redirect_pc <= np ? fepc : eipc;
          psw         <= np ? fepsw : eipsw;
        end else if (psw_we) begin
          psw <= psw_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reset_req,
  input logic        nmi_req,
  input logic [5:0]  irq,
  input logic [31:0] cur_pc,
  input logic        reti,
  input logic        redirect,
  input logic [31:0] redirect_pc,
  input logic [31:0] psw,
  input logic [31:0] ecr,
  input logic [31:0] fepc,
  input logic [31:0] fepsw,
  input logic [31:0] eipc,
  input logic [31:0] eipsw,
  input logic        nmi_pend
);
  p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> redirect && redirect_pc == 32'h0 && psw == 32'h20 && ecr == 32'h0 && !nmi_pend);

  p_nmi_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && nmi_req && !psw[7]) |=> redirect && redirect_pc == 32'h10 &&
      psw[7] && psw[5] && !psw[6] && fepc == $past(cur_pc) && fepsw == $past(psw) &&
      ecr[31:16] == 16'h0010 && ecr[15:0] == $past(ecr[15:0]));

  p_nmi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && nmi_req && psw[7]) |=> nmi_pend && $stable(fepc) && $stable(fepsw));

  p_mask_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && (psw[7] || psw[5])) |=> $stable(eipc) && $stable(eipsw));

  // R5 and R6: effects of taking a maskable line
  p_mask_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !nmi_req && !nmi_pend && !psw[7] && !psw[5] && irq != 6'b0) |=>
      redirect && psw[5] && !psw[6] && eipc == $past(cur_pc) && eipsw == $past(psw) &&
      ecr[31:16] == $past(ecr[31:16]) && ecr[15:0] == redirect_pc[15:0]);

  p_return_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && reti && psw[7]) |=> redirect && redirect_pc == $past(fepc) && psw == $past(fepsw));
endmodule

bind irq_accept irq_accept_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req), .irq(irq),
  .cur_pc(cur_pc), .reti(reti), .redirect(redirect), .redirect_pc(redirect_pc),
  .psw(psw), .ecr(ecr), .fepc(fepc), .fepsw(fepsw), .eipc(eipc), .eipsw(eipsw),
  .nmi_pend(nmi_pend)
);

// File: tb/tb_irq_accept.sv
`timescale 1ns/1ps
module tb_irq_accept;
  logic clk = 0, rst_n = 0;
  logic reset_req = 0, nmi_req = 0, reti = 0, psw_we = 0;
  logic [5:0]  irq = 0;
  logic [31:0] cur_pc = 0, psw_wdata = 0;
  logic redirect;
  logic [31:0] redirect_pc, psw, ecr, fepc, fepsw, eipc, eipsw;

  int n_chk = 0, n_fail = 0;
  logic done = 0;

  logic [31:0] m_psw = 32'h20, m_ecr = 0, m_fepc = 0, m_fepsw = 0, m_eipc = 0, m_eipsw = 0;
  logic m_pend = 0;

  always #2 clk = ~clk;

  irq_accept dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req), .irq(irq),
    .cur_pc(cur_pc), .reti(reti), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .redirect(redirect), .redirect_pc(redirect_pc), .psw(psw), .ecr(ecr),
    .fepc(fepc), .fepsw(fepsw), .eipc(eipc), .eipsw(eipsw));

  function automatic logic [31:0] line_vec(input logic [5:0] l);
    for (int k = 0; k < 6; k++) if (l[k]) return 32'h80 + 32'h10 * k;
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic rr, input logic nr, input logic [5:0] l, input logic rt,
                      input logic we, input logic [31:0] wd, input logic [31:0] pc);
    logic e_red;
    logic [31:0] e_tgt;
    string tag;
    @(negedge clk);
    reset_req = rr; nmi_req = nr; irq = l; reti = rt; psw_we = we; psw_wdata = wd; cur_pc = pc;
    e_red = 0; e_tgt = 0;
    if (rr) begin                                   // R1
      e_red = 1; m_psw = 32'h20; m_ecr = 0; m_pend = 0; tag = "R1";
    end else if ((nr | m_pend) & ~m_psw[7]) begin   // R2, R3, R7
      tag = m_pend ? "R3" : "R2";
      e_red = 1; e_tgt = 32'h10; m_fepc = pc; m_fepsw = m_psw;
      m_psw = (m_psw | 32'hA0) & ~32'h40; m_ecr = {16'h0010, m_ecr[15:0]};
      m_pend = m_pend & nr;
    end else begin
      m_pend = m_pend | nr;
      if (l != 0 && !m_psw[7] && !m_psw[5]) begin   // R5, R6, R7
        tag = "R6"; e_red = 1; e_tgt = line_vec(l); m_eipc = pc; m_eipsw = m_psw;
        m_psw = (m_psw | 32'h20) & ~32'h40; m_ecr = {m_ecr[31:16], e_tgt[15:0]};
      end else if (rt) begin                        // R8
        tag = "R8"; e_red = 1;
        if (m_psw[7]) begin e_tgt = m_fepc; m_psw = m_fepsw; end
        else begin e_tgt = m_eipc; m_psw = m_eipsw; end
      end else if (we) begin                        // R9
        tag = "R9"; m_psw = wd;
      end else tag = (l != 0) ? "R4" : "R10";
    end
    @(posedge clk); #1;
    check({tag, " redirect"}, 32'(redirect), 32'(e_red));
    if (e_red) check({tag, " target"}, redirect_pc, e_tgt);
    check({tag, " psw"}, psw, m_psw);
    check({tag, " ecr"}, ecr, m_ecr);
    check({tag, " fepc"}, fepc, m_fepc);
    check({tag, " fepsw"}, fepsw, m_fepsw);
    check({tag, " eipc"}, eipc, m_eipc);
    check({tag, " eipsw"}, eipsw, m_eipsw);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset psw", psw, 32'h20);
    check("R10 reset redirect", 32'(redirect), 0);
    // R9: enable interrupts
    step(0, 0, 6'b0, 0, 1, 32'h0, 32'h100);
    // R7: lines 3 and 5 together, line 3 wins (0xB0)
    step(0, 0, 6'b101000, 0, 0, 0, 32'h200);
    check("R7 vector", redirect_pc, 32'hB0);
    // R4: held line blocked while ID set; R9 write loses to nothing here but ID stays
    step(0, 0, 6'b101000, 0, 0, 0, 32'h204);
    step(0, 0, 6'b101000, 0, 0, 0, 32'h208);
    // R8: return restores, then line 5 taken next
    step(0, 0, 6'b100000, 1, 0, 0, 32'h20C);
    step(0, 0, 6'b100000, 0, 0, 0, 32'h300);
    check("R6 vector line5", redirect_pc, 32'hD0);
    step(0, 0, 6'b0, 1, 0, 0, 32'h304);
    // R2 then R3: two NMIs while NP set collapse to one
    step(0, 1, 6'b000001, 0, 0, 0, 32'h400);
    step(0, 1, 6'b0, 0, 0, 0, 32'h404);
    step(0, 1, 6'b0, 0, 0, 0, 32'h408);
    step(0, 0, 6'b0, 1, 0, 0, 32'h40C);
    step(0, 0, 6'b0, 0, 0, 0, 32'h410);
    check("R3 pending delivered", redirect_pc, 32'h10);
    step(0, 0, 6'b0, 1, 0, 0, 32'h414);
    step(0, 0, 6'b0, 0, 0, 0, 32'h418);
    check("R3 extra NMI dropped", 32'(redirect), 0);
    // R1: reset beats everything
    step(1, 1, 6'b111111, 1, 1, 32'hFFFF_FFFF, 32'h500);
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] l;
      l = (($urandom % 4) == 0) ? 6'($urandom) : 6'b0;
      step(($urandom % 128) == 0, ($urandom % 8) == 0, l, ($urandom % 6) == 0,
           ($urandom % 10) == 0, $urandom & 32'hFFFF_FF1F, $urandom);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule